// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Line Store

This block holds the lines of a small write-back cache. It has 32 sets of two ways, and each line carries a valid flag, a dirty flag, a 25-bit tag and a 128-bit block made of four 32-bit words. A request gives a set index, a tag and a word select. The store compares the tag against both ways of the set at once and answers within the same cycle with a hit flag and the selected word. A read or write enable then commits the access at the next clock edge. Each set keeps a single replacement bit, which always points away from the way that was touched last.

When a request misses, the controller outside this block drives the miss sequence. The store offers a victim candidate for the addressed set, taking an empty way first and the way named by the replacement bit otherwise, and reports whether that candidate holds modified data. A capture strobe freezes the candidate. From then on the captured way's block is presented for write-back, and a later refill strobe loads a memory block into that same way. Address splitting and the memory handshake are handled elsewhere.

Top module: `cache2w_store`

## Requirements
- R1: After reset no address hits, the victim-dirty output is 0, the captured way is 0, and every replacement bit is 0.
- R2: `hit` is 1 in the same cycle when either way of the addressed set is valid and holds the request tag. On a hit, `rd_word` is word k of that line's block, taken from bits 32k+31 down to 32k, where k is `word_sel`.
- R3: A read hit (`rd_en` with `hit`) does not change the line's dirty flag.
- R4: A write hit (`wr_en` with `hit`) replaces only the selected word of the hitting line and sets that line's dirty flag. The other three words keep their values.
- R5: A read hit, a write hit or a refill sets the set's replacement bit to name the other way. Replacement bit 0 names way 0 as the next victim and 1 names way 1.
- R6: The victim candidate is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way named by the replacement bit.
- R7: `victim_dirty` is 1 in the same cycle exactly when the victim candidate of the addressed set is both valid and dirty.
- R8: `miss_latch` captures the victim candidate into `fill_way` at the clock edge. `wb_block` shows the block of the captured way in the addressed set, and a refill writes that captured way even if the replacement bit has changed in between.
- R9: `refill_en` loads `refill_block` and the request tag into the captured way, marks the line valid and clean, and takes priority over a read or write enable in the same cycle.
- R10: A write miss, handled as capture, then refill, then write, leaves the line holding the written word and marked dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_idx | input | 5 | Set selected by the request |
| lookup_tag | input | 25 | Tag of the request |
| word_sel | input | 2 | Word within the block |
| rd_en | input | 1 | Commit a read access (updates replacement on hit) |
| wr_en | input | 1 | Commit a write access of `wr_word` on hit |
| wr_word | input | 32 | Word to write |
| miss_latch | input | 1 | Capture the current victim candidate |
| refill_en | input | 1 | Load `refill_block` into the captured way |
| refill_block | input | 128 | Block arriving from memory |
| hit | output | 1 | Tag match in either way |
| rd_word | output | 32 | Selected word of the hitting line |
| victim_dirty | output | 1 | Victim candidate is valid and dirty |
| fill_way | output | 1 | Captured victim way |
| wb_block | output | 128 | Block of the captured way, for write-back |

## Verification
`hit`, `rd_word`, `victim_dirty` and `wb_block` are combinational. They are due in the same cycle that the set, tag and word inputs are applied, and they reflect every access committed at earlier edges. `fill_way` and all stored state change at the rising edge that samples a strobe, so their effect first shows in the following cycle. The bench applies each step's inputs just after a falling edge and samples one nanosecond later, well before the committing edge. Every expected value therefore describes the state left by the previous steps only. Write-back contents are checked in the step after the capture, and dirty and replacement effects are checked through the victim-dirty output of later misses.

// File: rtl/cache2w_store.sv
module cache2w_store #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 32,
  parameter int TAG_W  = 25,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS),
  localparam int BLK_W = WORD_W * WORDS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] lookup_tag,
  input  logic [OFF_W-1:0] word_sel,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic             miss_latch,
  input  logic             refill_en,
  input  logic [BLK_W-1:0] refill_block,
  output logic             hit,
  output logic [WORD_W-1:0] rd_word,
  output logic             victim_dirty,
  output logic             fill_way,
  output logic [BLK_W-1:0] wb_block
);
  logic [1:0]       vld  [SETS];
  logic [1:0]       drt  [SETS];
  logic [SETS-1:0]  plru;
  logic [TAG_W-1:0] tg   [SETS][2];
  logic [BLK_W-1:0] blk  [SETS][2];

  logic [1:0] way_hit;
  logic       hway;
  logic       vic_now;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign way_hit[w] = vld[set_idx][w] && (tg[set_idx][w] == lookup_tag);
  end

  assign hit     = |way_hit;
  assign hway    = way_hit[1];
  assign rd_word = blk[set_idx][hway][word_sel*WORD_W +: WORD_W];

  assign vic_now = !vld[set_idx][0] ? 1'b0 :
                   !vld[set_idx][1] ? 1'b1 : plru[set_idx];
  assign victim_dirty = vld[set_idx][vic_now] && drt[set_idx][vic_now];
  assign wb_block     = blk[set_idx][fill_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        drt[s] <= '0;
      end
      plru     <= '0;
      fill_way <= 1'b0;
    end else begin
      if (miss_latch) fill_way <= vic_now;
      if (refill_en) begin
        vld[set_idx][fill_way] <= 1'b1;
        drt[set_idx][fill_way] <= 1'b0;
        plru[set_idx]          <= ~fill_way;
      end else if ((rd_en || wr_en) && hit) begin
        plru[set_idx] <= ~hway;
        if (wr_en) drt[set_idx][hway] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (refill_en) begin
        tg[set_idx][fill_way]  <= lookup_tag;
        blk[set_idx][fill_way] <= refill_block;
      end else if (wr_en && hit) begin
        blk[set_idx][hway][word_sel*WORD_W +: WORD_W] <= wr_word;
      end
    end
  end
endmodule

module cache2w_store_chk #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 32,
  parameter int TAG_W  = 25,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS),
  localparam int BLK_W = WORD_W * WORDS
) (
  input logic             clk,
  input logic             rst,
  input logic [IDX_W-1:0] set_idx,
  input logic [TAG_W-1:0] lookup_tag,
  input logic [OFF_W-1:0] word_sel,
  input logic             wr_en,
  input logic [WORD_W-1:0] wr_word,
  input logic             miss_latch,
  input logic             refill_en,
  input logic [BLK_W-1:0] refill_block,
  input logic             hit,
  input logic [WORD_W-1:0] rd_word,
  input logic             victim_dirty,
  input logic             fill_way,
  input logic             vic_now
);
  a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!hit && !victim_dirty && !fill_way));

  a_r8_capture_victim: assert property (@(posedge clk) disable iff (rst)
    miss_latch |=> (fill_way == $past(vic_now)));

  a_r9_refill_hits: assert property (@(posedge clk) disable iff (rst)
    (refill_en && !$fell(rst)) |=> (!(set_idx == $past(set_idx) && lookup_tag == $past(lookup_tag) &&
                      word_sel == $past(word_sel))
                    || (hit && rd_word == $past(refill_block[word_sel*WORD_W +: WORD_W]))));

  a_r4_write_readback: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit && !refill_en) |=> (!(set_idx == $past(set_idx) && lookup_tag == $past(lookup_tag) &&
                                        word_sel == $past(word_sel))
                                      || (hit && rd_word == $past(wr_word))));
endmodule

bind cache2w_store cache2w_store_chk #(
  .WORD_W(WORD_W), .WORDS(WORDS), .SETS(SETS), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst(rst), .set_idx(set_idx), .lookup_tag(lookup_tag), .word_sel(word_sel),
  .wr_en(wr_en), .wr_word(wr_word), .miss_latch(miss_latch), .refill_en(refill_en),
  .refill_block(refill_block), .hit(hit), .rd_word(rd_word), .victim_dirty(victim_dirty),
  .fill_way(fill_way), .vic_now(vic_now)
);

// File: tb/cache2w_store_test.sv
`timescale 1ns/1ps
module cache2w_store_test;
  logic         clk = 0;
  logic         rst = 1;
  logic [4:0]   set_idx = '0;
  logic [24:0]  lookup_tag = '0;
  logic [1:0]   word_sel = '0;
  logic         rd_en = 0, wr_en = 0, miss_latch = 0, refill_en = 0;
  logic [31:0]  wr_word = '0;
  logic [127:0] refill_block = '0;
  logic         hit, victim_dirty, fill_way;
  logic [31:0]  rd_word;
  logic [127:0] wb_block;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cache2w_store uut (
    .clk(clk), .rst(rst), .set_idx(set_idx), .lookup_tag(lookup_tag), .word_sel(word_sel),
    .rd_en(rd_en), .wr_en(wr_en), .wr_word(wr_word), .miss_latch(miss_latch),
    .refill_en(refill_en), .refill_block(refill_block), .hit(hit), .rd_word(rd_word),
    .victim_dirty(victim_dirty), .fill_way(fill_way), .wb_block(wb_block)
  );

  function automatic logic [31:0] wv(logic [24:0] t, int k);
    return {4'hB, t[19:0], 6'd0, 2'(k)};
  endfunction

  function automatic logic [127:0] mkblk(logic [24:0] t);
    return {wv(t, 3), wv(t, 2), wv(t, 1), wv(t, 0)};
  endfunction

  task automatic chk(string r, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  // op: 0 read, 1 write, 2 capture victim, 3 refill
  typedef struct packed {
    logic [1:0]  op;
    logic [24:0] tag;
    logic [1:0]  off;
    logic [31:0] wd;
    logic        eh;
    logic        evd;
    logic        efw;
    logic        chkw;
    logic [31:0] ew;
  } vec_t;

  localparam logic [24:0] TA = 25'h11, TB = 25'h22, TC = 25'h33;
  localparam logic [31:0] D1 = 32'hDEAD0001, D2 = 32'hDEAD0002;

  localparam vec_t TBL [16] = '{
    '{2'd0, TA, 2'd1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},        // compulsory miss
    '{2'd2, TA, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},        // R6 empty way 0
    '{2'd3, TA, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},        // R9 fill way 0
    '{2'd0, TA, 2'd2, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'hB0001102}, // R2 read word 2
    '{2'd0, TB, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},        // R6 empty way 1 candidate
    '{2'd2, TB, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{2'd3, TB, 2'd0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},        // R8 captured way 1
    '{2'd1, TA, 2'd1, D1,    1'b1, 1'b0, 1'b1, 1'b0, 32'h0},        // R4 write hit
    '{2'd0, TA, 2'd1, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1, D1},           // R4 readback
    '{2'd0, TA, 2'd0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1, 32'hB0001100}, // R4 neighbour intact
    '{2'd1, TB, 2'd3, D2,    1'b1, 1'b0, 1'b1, 1'b0, 32'h0},        // R5 plru to way 0
    '{2'd0, TC, 2'd0, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0},        // R3 R7 dirty way 0 victim
    '{2'd2, TC, 2'd0, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0},
    '{2'd3, TC, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},        // R8 write-back of way 0
    '{2'd0, TC, 2'd3, 32'h0, 1'b1, 1'b1, 1'b0, 1'b1, 32'hB0003303}, // R9 R5 victim now way 1
    '{2'd0, TA, 2'd1, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0}         // evicted line misses
  };

  task automatic step(logic [1:0] op, logic [4:0] s, logic [24:0] t, logic [1:0] off, logic [31:0] wd);
    @(negedge clk);
    set_idx = s; lookup_tag = t; word_sel = off; wr_word = wd;
    rd_en = (op == 2'd0); wr_en = (op == 2'd1);
    miss_latch = (op == 2'd2); refill_en = (op == 2'd3);
    refill_block = mkblk(t);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 0; wr_en = 0; miss_latch = 0; refill_en = 0;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    set_idx = 5'd3; lookup_tag = TA; #1;
    chk("R1 hit after reset", 128'(hit), 128'(0));
    chk("R1 victim_dirty after reset", 128'(victim_dirty), 128'(0));
    chk("R1 fill_way after reset", 128'(fill_way), 128'(0));

    for (int i = 0; i < 16; i++) begin
      step(TBL[i].op, 5'd3, TBL[i].tag, TBL[i].off, TBL[i].wd);
      chk("R2 hit", 128'(hit), 128'(TBL[i].eh));
      chk("R7 victim_dirty", 128'(victim_dirty), 128'(TBL[i].evd));
      chk("R8 fill_way", 128'(fill_way), 128'(TBL[i].efw));
      if (TBL[i].chkw) chk("R2 rd_word", 128'(rd_word), 128'(TBL[i].ew));
      if (i == 13) chk("R8 wb_block", wb_block, {wv(TA, 3), wv(TA, 2), D1, wv(TA, 0)});
    end

    // R10 write miss on set 7: capture, refill, write
    step(2'd2, 5'd7, 25'h44, 2'd2, 32'h0);
    step(2'd3, 5'd7, 25'h44, 2'd2, 32'h0);
    step(2'd1, 5'd7, 25'h44, 2'd2, 32'hCAFE0003);
    step(2'd0, 5'd7, 25'h44, 2'd2, 32'h0);
    chk("R10 written word", 128'(rd_word), 128'(32'hCAFE0003));
    step(2'd0, 5'd7, 25'h66, 2'd0, 32'h0);
    chk("R6 R7 empty way clean", 128'(victim_dirty), 128'(0));
    step(2'd2, 5'd7, 25'h55, 2'd0, 32'h0);
    step(2'd3, 5'd7, 25'h55, 2'd0, 32'h0);
    step(2'd0, 5'd7, 25'h66, 2'd0, 32'h0);
    chk("R10 line dirty after write miss", 128'(victim_dirty), 128'(1));
    chk("R9 refill priority hit", 128'(hit), 128'(0));
    // R9 refill wins over write in the same cycle
    step(2'd3, 5'd9, 25'h77, 2'd1, 32'h0);
    @(negedge clk);
    wr_en = 1; refill_en = 1; wr_word = 32'h12345678; #1;
    idle();
    set_idx = 5'd9; lookup_tag = 25'h77; word_sel = 2'd1; #1;
    chk("R9 refill over write", 128'(rd_word), 128'(wv(25'h77, 1)));

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; #1;
    set_idx = 5'd3; lookup_tag = TC; #1;
    chk("R1 hit after second reset", 128'(hit), 128'(0));
    chk("R1 victim_dirty after second reset", 128'(victim_dirty), 128'(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule